// File: doc/BRIEF.md
# Split-Phase Remote PUT/GET Engine

This block services remote memory messages that arrive as a stream of words from a network port. It does its work without any help from the local processor, and each message is handled to completion before the next one is taken. A PUT message stores its data block into local memory and then bumps a completion counter word, so the receiving software learns that the block has landed by watching that word. A GET request reads a block of local memory and sends it back to the requester as a freshly built PUT message on a separate reply port. A reply therefore never has to wait for the request stream to drain.

The engine drives a single-port synchronous memory with one cycle of read latency. Input and reply streams use valid/ready handshakes. The engine has no internal queue. While a reply word is stalled or the counter update is in progress, it holds the input off. A message whose first word is not a known handler code is discarded up to its end marker, and a one-cycle error pulse reports it.

Top module: `pg_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, in_ready is 1 and out_valid, mem_req and err are 0.
- R2: A PUT message is the word sequence code 0x1, destination address, length N, counter address, then N data words. Data word i is written to address destination+i, in ascending order.
- R3: After the last data word of a PUT, the counter word is read and then written back as its old value plus one, wrapping at the word width. This happens after every data write. The counter write takes effect at the third rising edge after the last data word is accepted, and the word is unchanged after the second edge.
- R4: A PUT with N = 0 makes exactly one memory write: the counter increment.
- R5: A GET request is the word sequence code 0x2, source address, length N, requester node, requester destination address, requester counter address. It writes nothing to local memory.
- R6: A GET produces on the reply port the words: requester node, 0x1, requester destination, N, requester counter address, then the local words at source+0 to source+N-1. out_valid is already high in the first cycle after the last request word is accepted.
- R7: out_last marks the final reply word. That is the counter-address word when N = 0, and the last data word otherwise.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last stay unchanged into the next cycle.
- R9: in_ready is 0 in every cycle in which out_valid is 1, so no request word is taken while a reply is in flight.
- R10: A first word other than 0x1 or 0x2 raises err for one cycle, starting in the cycle after that word is accepted. Words are discarded through the one marked by in_last. This causes no memory write and no reply word. in_last is ignored for PUT and GET framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request word available |
| in_ready | output | 1 | Engine takes the request word this cycle |
| in_data | input | DW | Request word |
| in_last | input | 1 | Final word of the request message (used only to discard unknown messages) |
| out_valid | output | 1 | Reply word available |
| out_ready | input | 1 | Reply network takes the word this cycle |
| out_data | output | DW | Reply word |
| out_last | output | 1 | Final word of the reply message |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| err | output | 1 | One-cycle pulse for a dropped message |

## Verification
A PUT data word lands in memory at the edge that accepts it. The counter write comes three edges after the last data word, so the bench samples the counter just after the second edge, expecting the old value, and again just after the third, expecting old+1. The first reply word is due one cycle after the last GET word is accepted. After that, each data word needs a read, a capture and a present cycle plus any stall cycles, so reply words are compared when they are actually handed over rather than at fixed times. The err pulse is due one cycle after a bad code is accepted and is sampled right after that edge. Stall stability and input hold-off are checked on every cycle between edges, while out_ready is held still.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;

    localparam int unsigned CODE_PUT = 1;
    localparam int unsigned CODE_GET = 2;

    typedef enum logic [4:0] {
        ST_HDR,
        ST_DROP,
        ST_ADR,
        ST_LEN,
        ST_W3,
        ST_W4,
        ST_W5,
        ST_PDATA,
        ST_FRD,
        ST_FWAIT,
        ST_FWR,
        ST_RNODE,
        ST_RCODE,
        ST_RDST,
        ST_RLEN,
        ST_RFLG,
        ST_GRD,
        ST_GCAP,
        ST_GOUT
    } state_e;

endpackage

// File: rtl/pg_decode.sv
`timescale 1ns/1ps
module pg_decode #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] code,
    output logic          is_put,
    output logic          is_get
);
    always_comb begin
        is_put = (code == DW'(pg_pkg::CODE_PUT));
        is_get = (code == DW'(pg_pkg::CODE_GET));
    end
endmodule

// File: rtl/pg_cnt.sv
`timescale 1ns/1ps
module pg_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - W'(1);
        end
        is_zero = (cnt_q == '0);
        is_one  = (cnt_q == W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !is_zero);
endmodule

// File: rtl/pg_engine.sv
`timescale 1ns/1ps
module pg_engine #(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          err
);
    import pg_pkg::*;

    localparam logic [AW-1:0] ADDR_STEP = AW'(1);
    localparam logic [DW-1:0] FLAG_STEP = DW'(1);

    typedef struct packed {
        state_e        st;
        logic          is_get;
        logic [AW-1:0] addr;
        logic [AW-1:0] flag;
        logic [LW-1:0] len;
        logic [DW-1:0] node;
        logic [AW-1:0] rdst;
        logic [AW-1:0] rflag;
        logic [DW-1:0] data;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;

    logic hdr_put, hdr_get;
    logic cnt_load, cnt_dec, cnt_zero, cnt_one;

    pg_decode #(.DW(DW)) u_decode (
        .code   (in_data),
        .is_put (hdr_put),
        .is_get (hdr_get)
    );

    pg_cnt #(.W(LW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (in_data[LW-1:0]),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.addr;
        mem_wdata = in_data;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;

        case (r_q.st)
            ST_HDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (hdr_put) begin
                        r_d.is_get = 1'b0;
                        r_d.st     = ST_ADR;
                    end else if (hdr_get) begin
                        r_d.is_get = 1'b1;
                        r_d.st     = ST_ADR;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.st  = in_last ? ST_HDR : ST_DROP;
                    end
                end
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    r_d.st = ST_HDR;
                end
            end
            ST_ADR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.addr = in_data[AW-1:0];
                    r_d.st   = ST_LEN;
                end
            end
            ST_LEN: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.len  = in_data[LW-1:0];
                    cnt_load = 1'b1;
                    r_d.st   = ST_W3;
                end
            end
            ST_W3: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (r_q.is_get) begin
                        r_d.node = in_data;
                        r_d.st   = ST_W4;
                    end else begin
                        r_d.flag = in_data[AW-1:0];
                        r_d.st   = cnt_zero ? ST_FRD : ST_PDATA;
                    end
                end
            end
            ST_W4: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.rdst = in_data[AW-1:0];
                    r_d.st   = ST_W5;
                end
            end
            ST_W5: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.rflag = in_data[AW-1:0];
                    r_d.st    = ST_RNODE;
                end
            end
            ST_PDATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = r_q.addr;
                    r_d.addr = r_q.addr + ADDR_STEP;
                    cnt_dec  = 1'b1;
                    if (cnt_one) begin
                        r_d.st = ST_FRD;
                    end
                end
            end
            ST_FRD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.flag;
                r_d.st   = ST_FWAIT;
            end
            ST_FWAIT: begin
                r_d.data = mem_rdata + FLAG_STEP;
                r_d.st   = ST_FWR;
            end
            ST_FWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.flag;
                mem_wdata = r_q.data;
                r_d.st    = ST_HDR;
            end
            ST_RNODE: begin
                out_valid = 1'b1;
                out_data  = r_q.node;
                if (out_ready) r_d.st = ST_RCODE;
            end
            ST_RCODE: begin
                out_valid = 1'b1;
                out_data  = DW'(CODE_PUT);
                if (out_ready) r_d.st = ST_RDST;
            end
            ST_RDST: begin
                out_valid = 1'b1;
                out_data  = DW'(r_q.rdst);
                if (out_ready) r_d.st = ST_RLEN;
            end
            ST_RLEN: begin
                out_valid = 1'b1;
                out_data  = DW'(r_q.len);
                if (out_ready) r_d.st = ST_RFLG;
            end
            ST_RFLG: begin
                out_valid = 1'b1;
                out_data  = DW'(r_q.rflag);
                out_last  = cnt_zero;
                if (out_ready) r_d.st = cnt_zero ? ST_HDR : ST_GRD;
            end
            ST_GRD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.addr;
                r_d.addr = r_q.addr + ADDR_STEP;
                cnt_dec  = 1'b1;
                r_d.st   = ST_GCAP;
            end
            ST_GCAP: begin
                r_d.data = mem_rdata;
                r_d.st   = ST_GOUT;
            end
            ST_GOUT: begin
                out_valid = 1'b1;
                out_data  = r_q.data;
                out_last  = cnt_zero;
                if (out_ready) r_d.st = cnt_zero ? ST_HDR : ST_GRD;
            end
            default: begin
                r_d.st = ST_HDR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign err = r_q.err;

    // R8
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10
    err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(in_valid && in_ready));

    // R6
    reply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(in_valid && in_ready) || $past(mem_req && !mem_we, 2)));
endmodule

// File: tb/pg_engine_bench.sv
`timescale 1ns/1ps
module pg_engine_bench;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          out_last;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          err;

    pg_engine #(.DW(DW), .AW(AW), .LW(LW)) u_pg_engine (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .err(err)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] seed(input int i);
        return 32'h1000_0000 + i * 3;
    endfunction

    // bench memory with one cycle of read latency
    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= seed(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // write log
    logic [7:0] wr_log [1024];
    int wr_n = 0;
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_we) begin
            wr_log[wr_n] <= mem_addr;
            wr_n <= wr_n + 1;
        end
    end

    // stall pattern for the reply port
    int stall_mode = 0;
    int rcyc = 0;
    always @(posedge clk) begin
        #2;
        rcyc++;
        if (stall_mode == 0) out_ready = 1'b1;
        else                 out_ready = ((rcyc % 3) == 0) || ((rcyc % 7) == 2);
    end

    // expected reply words, written by the main flow, consumed by the monitor
    logic [31:0] exp_data [512];
    logic        exp_last [512];
    int exp_wr = 0;
    int exp_rd = 0;
    int mon_total = 0;
    int mon_bad = 0;
    int err_seen = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic        prev_lst = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                mon_total++;
                if (in_ready) begin
                    mon_bad++;
                    $display("FAIL R9 in_ready act=%0d exp=0 while reply valid", in_ready);
                end
            end
            if (prev_stall) begin
                mon_total++;
                if (!out_valid || out_data != prev_data || out_last != prev_lst) begin
                    mon_bad++;
                    $display("FAIL R8 stalled word act=%h/%0d exp=%h/1", out_data, out_valid, prev_data);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_lst   = out_last;
            if (out_valid && out_ready) begin
                mon_total++;
                if (exp_rd >= exp_wr) begin
                    mon_bad++;
                    $display("FAIL R6 unexpected reply word act=%h exp=none", out_data);
                end else begin
                    if (out_data != exp_data[exp_rd] || out_last != exp_last[exp_rd]) begin
                        mon_bad++;
                        $display("FAIL R6/R7 reply word %0d act=%h last=%0d exp=%h last=%0d",
                                 exp_rd, out_data, out_last, exp_data[exp_rd], exp_last[exp_rd]);
                    end
                    exp_rd++;
                end
            end
            if (err) err_seen++;
        end
    end

    int total = 0;
    int bad = 0;
    logic [31:0] ref_mem [256];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic push_exp(input logic [31:0] d, input logic l);
        exp_data[exp_wr] = d;
        exp_last[exp_wr] = l;
        exp_wr++;
    endtask

    task automatic send_word(input logic [31:0] w, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        in_last  = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic do_put(input logic [7:0] dst, input int len, input logic [7:0] flg, input int base);
        int wb;
        logic [31:0] old_flag;
        logic [7:0] a;
        wb = wr_n;
        for (int k = 0; k < len; k++) begin
            a = dst + 8'(k);
            ref_mem[a] = 32'(base + k * 7);
        end
        old_flag = ref_mem[flg];
        ref_mem[flg] = ref_mem[flg] + 32'd1;
        send_word(32'h1, 1'b0);
        send_word(32'(dst), 1'b0);
        send_word(32'(len), 1'b0);
        send_word(32'(flg), 1'b0);
        for (int k = 0; k < len; k++) send_word(32'(base + k * 7), 1'b0);
        @(posedge clk);
        @(posedge clk);
        #1;
        chk(mem[flg] == old_flag, "R3 counter not yet updated", mem[flg], old_flag);
        @(posedge clk);
        #1;
        chk(mem[flg] == ref_mem[flg], "R3 counter incremented", mem[flg], ref_mem[flg]);
        chk(wr_n - wb == len + 1, (len == 0) ? "R4 write count" : "R2 write count",
            32'(wr_n - wb), 32'(len + 1));
        for (int k = 0; k < len; k++) begin
            a = dst + 8'(k);
            chk(wr_log[wb + k] == a, "R2 write order", 32'(wr_log[wb + k]), 32'(a));
            chk(mem[a] == ref_mem[a], "R2 data word", mem[a], ref_mem[a]);
        end
        chk(wr_log[wb + len] == flg, "R3 counter written last", 32'(wr_log[wb + len]), 32'(flg));
    endtask

    task automatic do_get(input logic [7:0] src, input int len, input logic [31:0] node,
                          input logic [7:0] rdst, input logic [7:0] rflg, input int mode);
        int wb;
        logic [7:0] a;
        wb = wr_n;
        push_exp(node, 1'b0);
        push_exp(32'h1, 1'b0);
        push_exp(32'(rdst), 1'b0);
        push_exp(32'(len), 1'b0);
        push_exp(32'(rflg), len == 0);
        for (int k = 0; k < len; k++) begin
            a = src + 8'(k);
            push_exp(ref_mem[a], k == len - 1);
        end
        stall_mode = mode;
        send_word(32'h2, 1'b0);
        send_word(32'(src), 1'b0);
        send_word(32'(len), 1'b0);
        send_word(node, 1'b0);
        send_word(32'(rdst), 1'b0);
        send_word(32'(rflg), 1'b0);
        chk(out_valid == 1'b1, "R6 reply starts one cycle after request", 32'(out_valid), 32'h1);
        while (exp_rd != exp_wr) @(negedge clk);
        @(negedge clk);
        chk(exp_rd == exp_wr, "R6 reply word count", 32'(exp_rd), 32'(exp_wr));
        chk(wr_n == wb, "R5 no memory write on GET", 32'(wr_n - wb), 32'h0);
        stall_mode = 0;
    endtask

    task automatic do_bad(input logic [31:0] code, input int extra);
        int wb, eb, xb;
        wb = wr_n;
        eb = err_seen;
        xb = exp_rd;
        send_word(code, extra == 0);
        chk(err == 1'b1, "R10 err pulse after bad code", 32'(err), 32'h1);
        for (int k = 0; k < extra; k++) send_word(32'h0000_0010 + 32'(k), k == extra - 1);
        repeat (4) @(negedge clk);
        chk(err_seen - eb == 1, "R10 err pulse length", 32'(err_seen - eb), 32'h1);
        chk(wr_n == wb, "R10 no memory write", 32'(wr_n - wb), 32'h0);
        chk(exp_rd == xb && !out_valid, "R10 no reply", 32'(out_valid), 32'h0);
    endtask

    initial begin
        int mism;
        for (int i = 0; i < 256; i++) ref_mem[i] = seed(i);
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && mem_req == 1'b0 && err == 1'b0,
            "R1 state during reset", {in_ready, out_valid, mem_req, err}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && mem_req == 1'b0 && err == 1'b0,
            "R1 state after reset", {in_ready, out_valid, mem_req, err}, 32'h8);

        do_put(8'h10, 4, 8'h40, 32'h100);          // R2 R3
        do_put(8'h20, 1, 8'h40, 32'h200);          // R2 single word
        do_put(8'h00, 0, 8'h41, 0);                // R4
        do_get(8'h10, 3, 32'h0000_0007, 8'h80, 8'h90, 1);  // R6 R7 R8 with stalls
        do_get(8'h33, 0, 32'h0000_0003, 8'h44, 8'h55, 0);  // R7 zero length
        do_bad(32'h3, 2);                          // R10 multi-word drop
        do_bad(32'h0, 0);                          // R10 single-word drop
        do_put(8'hFE, 3, 8'h50, 32'h300);          // R2 address wrap
        do_put(8'h60, 1, 8'h60, 32'hFFFF_FFFF);    // R3 counter inside block
        do_put(8'h70, 0, 8'h61, 0);                // R4 again
        do_get(8'hFE, 4, 32'h0000_00AA, 8'h01, 8'h02, 1);  // R6 with wrap and stalls
        do_put(8'h90, 2, 8'h91, 32'h400);          // R9 directly after GET

        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != ref_mem[i]) mism++;
        chk(mism == 0, "R2 final memory image", 32'(mism), 32'h0);

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
        $finish;
    end
endmodule